// File: doc/BRIEF.md
# Twin Timer/Counter with Split, PWM and Toggle Modes

This block holds two 16-bit timer/counters, timer 0 and timer 1, each built from a low byte and a high byte. A timer advances only on cycles where a shared clock-enable tick is high and its run bit is set. Each timer has a three-bit mode select:

- **13-bit prescaled count (0).** The low five bits act as a prescaler below the 8-bit high byte.
- **Plain 16-bit count (1).**
- **8-bit auto-reload (2).** The low byte counts and is refilled from the high byte when it wraps.
- **Split (3).**
- **256-tick PWM (6).**

The remaining codes (4, 5 and 7) hold the count.

When timer 0 is split, its two bytes become two independent 8-bit counters. When timer 1 is put in the split code, it freezes. Timer 1 wrapping is always exported as a one-cycle baud tick for a serial port, even when it can no longer raise its own flag.

Software loads a timer's 16-bit count through a write strobe and clears flags through clear strobes. In PWM mode the high byte serves as the compare value, and it is captured only at the period wrap. Timer 0 also drives a pin value. In PWM mode that value is the PWM waveform. With toggle output enabled, the value inverts on every timer 0 wrap and starts high. A matching pin-enable output tells the pad to treat the shared pin as an output instead of a count input.

Top module: `twin_timer`

## Requirements
- R1: After reset both flags are 0, baudTick is 0, t0Pin is 1, and both pin enables are 0.
- R2: A timer advances only on cycles where tick is 1 and its run bit is 1 (timer 1 in addition runs, ignoring run[1], while timer 0 is split); with either missing, a loaded count is held.
- R3: In mode 1 a timer counts the full 16-bit value and sets its flag on the tick that takes it from 0xFFFF to 0, so a load of L gives the flag after 65536-L ticks.
- R4: In mode 0 the low five bits of the low byte form a prescaler below the 8-bit high byte; the flag is set when both wrap together, so a load of {0xFF, 0x10} gives the flag after 16 ticks and {0xFE, 0x1F} after 33.
- R5: In mode 2 the low byte counts and, on wrapping, reloads from the high byte and sets the flag, giving a period of 256 minus the high byte.
- R6: With timer 0 in mode 3, its low byte counts under run[0] and sets flag[0], and its high byte counts under run[1] and sets flag[1]; timer 1 wraps then no longer set flag[1].
- R7: Timer 1 in mode 3 holds its count and produces neither baudTick nor a flag; returning it to a counting mode resumes from the held value.
- R8: baudTick is a one-cycle pulse, aligned with the flag update, on every timer 1 wrap, including while timer 0 is split.
- R9: In mode 6 the timer's pin is 1 while the low byte is below the captured compare byte and 0 otherwise, so each 256-tick period is high for exactly as many ticks as the compare value (0 to 255); the pin enable is 1.
- R10: In mode 6 a new high byte takes effect as the compare value only at the next wrap from 0xFF to 0; the period in progress keeps the old compare.
- R11: With toggleEn at 1, t0Pin is 1 until the first timer 0 wrap and inverts on each wrap; with toggleEn at 0 the toggle state is forced back to 1, so re-enabling starts high again.
- R12: A flag set and its clear strobe in the same cycle leave the flag set; a clear strobe alone clears it.
- R13: A count write in the same cycle as a tick loads the written value unchanged, and that cycle produces no wrap or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-enable tick for both timers |
| run | input | 2 | Run bits, bit 0 for timer 0, bit 1 for timer 1 |
| mode0 | input | 3 | Timer 0 mode: 0, 1, 2, 3 or 6 |
| mode1 | input | 3 | Timer 1 mode: 0, 1, 2, 3 or 6 |
| toggleEn | input | 1 | Enables the timer 0 toggle output |
| cntWr | input | 2 | Count write strobes per timer |
| cntWrData | input | 16 | Write value, high byte in bits 15:8 |
| flagClr | input | 2 | Flag clear strobes per timer |
| flag | output | 2 | Overflow flags |
| baudTick | output | 1 | One-cycle pulse per timer 1 wrap |
| t0Pin | output | 1 | Timer 0 pin value (PWM or toggle) |
| t0PinEn | output | 1 | Timer 0 pin drives as output |
| t1Pin | output | 1 | Timer 1 PWM pin value |
| t1PinEn | output | 1 | Timer 1 pin drives as output |

## Verification
Two things can land on a flag in the same cycle: a wrap and a software clear. The bench parks a timer at 0xFFFF and applies a tick together with the clear strobe, then expects the flag to read 1; a second, lone clear must then read 0. The same applies to a count write against a tick. A write issued on the wrapping tick must suppress that flag, and the following count to the next flag must match the written value exactly. PWM duty is swept over every compare value, and a mid-period compare change is judged against the old and new duties.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_13BIT  = 3'd0,
    M_16BIT  = 3'd1,
    M_RELOAD = 3'd2,
    M_SPLIT  = 3'd3,
    M_PWM    = 3'd6
  } tmr_mode_e;

  // count strobes from control to datapath
  typedef struct packed {
    logic [1:0] stepLo;
    logic [1:0] stepHi;
  } step_s;

  // wrap events from datapath back to control
  typedef struct packed {
    logic [1:0] wrap;
    logic [1:0] wrapHi;
  } wrap_s;

  function automatic logic validMode(input logic [2:0] m);
    return (m == M_13BIT) || (m == M_16BIT) || (m == M_RELOAD) ||
           (m == M_SPLIT) || (m == M_PWM);
  endfunction

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  step_s                 step,
  input  logic [1:0][2:0]       modeSel,
  input  logic [1:0]            wr,
  input  logic [2*HALF_W-1:0]   wrData,
  output wrap_s                 wrapEv,
  output logic [1:0]            pwm
);

  logic [1:0] wrapV;
  logic [1:0] wrapHiV;

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic [HALF_W-1:0] loQ, hiQ, cmpQ;
    logic [HALF_W-1:0] loN, hiN, cmpN;
    logic              wrapN, wrapHiN;

    always_comb begin
      loN     = loQ;
      hiN     = hiQ;
      cmpN    = cmpQ;
      wrapN   = 1'b0;
      wrapHiN = 1'b0;
      if (step.stepLo[t]) begin
        case (modeSel[t])
          M_13BIT: begin
            if (&loQ[PRE_W-1:0]) begin
              loN[PRE_W-1:0] = '0;
              hiN            = hiQ + 1'b1;
              wrapN          = &hiQ;
            end else begin
              loN[PRE_W-1:0] = loQ[PRE_W-1:0] + 1'b1;
            end
          end
          M_16BIT: begin
            {hiN, loN} = {hiQ, loQ} + 1'b1;
            wrapN      = &{hiQ, loQ};
          end
          M_RELOAD: begin
            if (&loQ) begin
              loN   = hiQ;
              wrapN = 1'b1;
            end else begin
              loN = loQ + 1'b1;
            end
          end
          M_SPLIT: begin
            loN   = loQ + 1'b1;
            wrapN = &loQ;
          end
          M_PWM: begin
            loN = loQ + 1'b1;
            if (&loQ) begin
              wrapN = 1'b1;
              cmpN  = hiQ;
            end
          end
          default: ;
        endcase
      end
      if (step.stepHi[t]) begin
        hiN     = hiQ + 1'b1;
        wrapHiN = &hiQ;
      end
      if (wr[t]) begin
        {hiN, loN} = wrData;
        wrapN      = 1'b0;
        wrapHiN    = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        loQ  <= '0;
        hiQ  <= '0;
        cmpQ <= '0;
      end else begin
        loQ  <= loN;
        hiQ  <= hiN;
        cmpQ <= cmpN;
      end
    end

    assign wrapV[t]   = wrapN;
    assign wrapHiV[t] = wrapHiN;
    assign pwm[t]     = loQ < cmpQ;
  end

  assign wrapEv.wrap   = wrapV;
  assign wrapEv.wrapHi = wrapHiV;

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [1:0]      run,
  input  logic [1:0][2:0] modeSel,
  input  logic            toggleEn,
  input  logic [1:0]      flagClr,
  input  wrap_s           wrapEv,
  output step_s           step,
  output logic [1:0]      flag,
  output logic            baudTick,
  output logic            togQ
);

  logic       split;
  logic [1:0] setFlag;

  assign split = modeSel[0] == M_SPLIT;

  always_comb begin
    step.stepLo[0] = tick & run[0] & validMode(modeSel[0]);
    step.stepHi[0] = tick & run[1] & split;
    step.stepHi[1] = 1'b0;
    step.stepLo[1] = tick & validMode(modeSel[1]) &
                     (modeSel[1] != M_SPLIT) & (run[1] | split);
  end

  assign setFlag[0] = wrapEv.wrap[0];
  assign setFlag[1] = split ? wrapEv.wrapHi[0] : wrapEv.wrap[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= '0;
      baudTick <= 1'b0;
      togQ     <= 1'b1;
    end else begin
      flag     <= setFlag | (flag & ~flagClr);
      baudTick <= wrapEv.wrap[1];
      togQ     <= toggleEn ? (togQ ^ wrapEv.wrap[0]) : 1'b1;
    end
  end

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          run,
  input  logic [2:0]          mode0,
  input  logic [2:0]          mode1,
  input  logic                toggleEn,
  input  logic [1:0]          cntWr,
  input  logic [2*HALF_W-1:0] cntWrData,
  input  logic [1:0]          flagClr,
  output logic [1:0]          flag,
  output logic                baudTick,
  output logic                t0Pin,
  output logic                t0PinEn,
  output logic                t1Pin,
  output logic                t1PinEn
);

  logic [1:0][2:0] modeSel;
  step_s           step;
  wrap_s           wrapEv;
  logic [1:0]      pwm;
  logic            togQ;

  assign modeSel = {mode1, mode0};

  tmr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .modeSel(modeSel),
    .toggleEn(toggleEn), .flagClr(flagClr), .wrapEv(wrapEv), .step(step),
    .flag(flag), .baudTick(baudTick), .togQ(togQ)
  );

  tmr_datapath #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rst(rst), .step(step), .modeSel(modeSel), .wr(cntWr),
    .wrData(cntWrData), .wrapEv(wrapEv), .pwm(pwm)
  );

  assign t0Pin   = (mode0 == M_PWM) ? pwm[0] : togQ;
  assign t0PinEn = toggleEn | (mode0 == M_PWM);
  assign t1Pin   = (mode1 == M_PWM) & pwm[1];
  assign t1PinEn = mode1 == M_PWM;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] run,
  input logic [2:0] mode0,
  input logic [2:0] mode1,
  input logic       toggleEn,
  input logic [1:0] cntWr,
  input logic [1:0] flagClr,
  input logic [1:0] flag,
  input logic       baudTick,
  input logic       t0Pin
);

  a_r2_flag_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[0]) |-> $past(tick));

  a_r6_split_hi_needs_run1: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag[1]) && $past(mode0) == 3'd3) |-> $past(run[1]));

  a_r7_halted_t1_silent: assert property (@(posedge clk) disable iff (rst)
    (mode1 == 3'd3) |=> !baudTick);

  a_r11_toggle_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!toggleEn && mode0 != 3'd6) |=> (t0Pin || mode0 == 3'd6));

  a_r12_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (flag[0] && !flagClr[0]) |=> flag[0]);

  a_r13_write_no_flag: assert property (@(posedge clk) disable iff (rst)
    (cntWr[0] && !flag[0]) |=> !flag[0]);

endmodule

bind twin_timer tmr_checker chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run), .mode0(mode0),
  .mode1(mode1), .toggleEn(toggleEn), .cntWr(cntWr), .flagClr(flagClr),
  .flag(flag), .baudTick(baudTick), .t0Pin(t0Pin)
);

// File: tb/twin_timer_test.sv
`timescale 1ns/1ps
module twin_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  run = '0;
  logic [2:0]  mode0 = '0;
  logic [2:0]  mode1 = '0;
  logic        toggleEn = 1'b0;
  logic [1:0]  cntWr = '0;
  logic [15:0] cntWrData = '0;
  logic [1:0]  flagClr = '0;
  logic [1:0]  flag;
  logic        baudTick, t0Pin, t0PinEn, t1Pin, t1PinEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twin_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .mode0(mode0),
    .mode1(mode1), .toggleEn(toggleEn), .cntWr(cntWr),
    .cntWrData(cntWrData), .flagClr(flagClr), .flag(flag),
    .baudTick(baudTick), .t0Pin(t0Pin), .t0PinEn(t0PinEn),
    .t1Pin(t1Pin), .t1PinEn(t1PinEn)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; tick = 0; run = 0; mode0 = 0; mode1 = 0; toggleEn = 0;
    cntWr = 0; flagClr = 0;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic load(input int t, input logic [15:0] d);
    cntWr[t] = 1'b1; cntWrData = d;
    cyc();
    cntWr = '0;
  endtask

  task automatic clearFlags();
    flagClr = 2'b11; cyc(); flagClr = 2'b00;
  endtask

  task automatic ticksToFlag(input int idx, input int limit, output int n);
    n = 0;
    while (!flag[idx] && n < limit) begin
      tick = 1'b1; cyc(); n++;
    end
    tick = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc();
    end
    tick = 1'b0;
  endtask

  // counts high samples of a pin over n ticks, sampling before each tick
  task automatic dutyCount(input int pinSel, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if ((pinSel == 0 ? t0Pin : t1Pin) == 1'b1) hi++;
      tick = 1'b1; cyc();
    end
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, hi, bc;
    @(negedge clk);
    doReset();

    // R1 reset state
    check("R1 flags", flag, 0);
    check("R1 baudTick", baudTick, 0);
    check("R1 t0Pin", t0Pin, 1);
    check("R1 pin enables", {t0PinEn, t1PinEn}, 0);

    // R2 gating by tick and run
    mode0 = 3'd1; load(0, 16'hFFFF);
    run = 2'b01; tick = 0; for (int i = 0; i < 20; i++) cyc();
    check("R2 run without tick", flag[0], 0);
    run = 2'b00; tickN(20);
    check("R2 tick without run", flag[0], 0);
    run = 2'b01; ticksToFlag(0, 10, n);
    check("R2 resume held count", n, 1);

    // R3 16-bit counts
    doReset(); mode0 = 3'd1; run = 2'b01;
    load(0, 16'hFFF0); ticksToFlag(0, 70000, n); check("R3 load FFF0", n, 16);
    clearFlags(); load(0, 16'hFF00); ticksToFlag(0, 70000, n); check("R3 load FF00", n, 256);
    mode1 = 3'd1; run = 2'b10; load(1, 16'hFFFA);
    ticksToFlag(1, 70000, n); check("R3 timer1 load FFFA", n, 6);

    // R4 13-bit counts
    doReset(); mode0 = 3'd0; run = 2'b01;
    load(0, 16'hFF10); ticksToFlag(0, 9000, n); check("R4 load FF10", n, 16);
    clearFlags(); load(0, 16'hFE1F); ticksToFlag(0, 9000, n); check("R4 load FE1F", n, 33);

    // R5 auto-reload
    doReset(); mode0 = 3'd2; run = 2'b01;
    load(0, 16'hF0FE); ticksToFlag(0, 1000, n); check("R5 first wrap", n, 2);
    clearFlags(); ticksToFlag(0, 1000, n); check("R5 reload period", n, 16);
    clearFlags(); ticksToFlag(0, 1000, n); check("R5 reload period again", n, 16);

    // R6 split timer 0
    doReset(); mode0 = 3'd3; mode1 = 3'd1; run = 2'b01;
    load(0, 16'hF8F0); ticksToFlag(0, 1000, n);
    check("R6 low half wrap", n, 16);
    check("R6 high half idle under run0", flag[1], 0);
    clearFlags(); run = 2'b10; ticksToFlag(1, 1000, n);
    check("R6 high half wrap", n, 8);
    check("R6 low half idle under run1", flag[0], 0);

    // R8 baud export during split
    doReset(); mode0 = 3'd3; mode1 = 3'd2; run = 2'b00;
    load(1, 16'hFCFC); bc = 0;
    for (int i = 0; i < 40; i++) begin
      tick = 1'b1; cyc(); if (baudTick) bc++;
    end
    tick = 1'b0;
    check("R8 baud pulses", bc, 10);
    check("R8 timer1 flag untouched", flag[1], 0);

    // R7 timer 1 halted
    doReset(); mode0 = 3'd1; mode1 = 3'd3; run = 2'b10;
    load(1, 16'hFFFF); bc = 0;
    for (int i = 0; i < 50; i++) begin
      tick = 1'b1; cyc(); if (baudTick) bc++;
    end
    tick = 1'b0;
    check("R7 no baud when halted", bc, 0);
    check("R7 no flag when halted", flag[1], 0);
    mode1 = 3'd1; ticksToFlag(1, 10, n);
    check("R7 resumes held count", n, 1);

    // R12 set and clear same cycle
    doReset(); mode0 = 3'd1; run = 2'b01; load(0, 16'hFFFF);
    tick = 1'b1; flagClr = 2'b01; cyc(); tick = 1'b0; flagClr = 2'b00;
    check("R12 set beats clear", flag[0], 1);
    flagClr = 2'b01; cyc(); flagClr = 2'b00;
    check("R12 clear alone", flag[0], 0);

    // R13 write beats tick
    doReset(); mode0 = 3'd1; run = 2'b01; load(0, 16'hFFFF);
    tick = 1'b1; cntWr = 2'b01; cntWrData = 16'hFFF0; cyc();
    tick = 1'b0; cntWr = 2'b00;
    check("R13 no flag on write cycle", flag[0], 0);
    ticksToFlag(0, 1000, n); check("R13 written value exact", n, 16);

    // R11 toggle output
    doReset(); mode0 = 3'd2; load(0, 16'hFCFC);
    toggleEn = 1'b1; cyc();
    check("R11 starts high", t0Pin, 1);
    check("R11 pin enable", t0PinEn, 1);
    run = 2'b01; tickN(3); check("R11 high before first wrap", t0Pin, 1);
    tickN(1); check("R11 first wrap", t0Pin, 0);
    tickN(4); check("R11 second wrap", t0Pin, 1);
    tickN(4); check("R11 third wrap", t0Pin, 0);
    run = 2'b00; toggleEn = 1'b0; cyc();
    check("R11 disabled forces high", t0Pin, 1);
    toggleEn = 1'b1; cyc();
    check("R11 re-enable starts high", t0Pin, 1);

    // R9 PWM duty sweep, timer 0 all compare values
    doReset(); mode0 = 3'd6; run = 2'b01;
    for (int c = 0; c < 256; c++) begin
      load(0, {c[7:0], 8'hFF});
      tickN(1);
      dutyCount(0, 256, hi);
      if (hi != c) check("R9 timer0 duty", hi, c); else checks++;
    end
    check("R9 timer0 pin enable", t0PinEn, 1);
    mode1 = 3'd6; run = 2'b10;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 128 : 255;
      load(1, {c[7:0], 8'hFF});
      tickN(1);
      dutyCount(1, 256, hi);
      check("R9 timer1 duty", hi, c);
    end
    check("R9 timer1 pin enable", t1PinEn, 1);

    // R10 compare captured only at wrap
    doReset(); mode0 = 3'd6; run = 2'b01;
    load(0, 16'h64FF); tickN(1); tickN(10);
    load(0, 16'hC80A);
    dutyCount(0, 246, hi);
    check("R10 old compare rest of period", hi, 90);
    dutyCount(0, 256, hi);
    check("R10 new compare next period", hi, 200);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule